// File: doc/BRIEF.md
# Custodian Parity Extension Controller

This controller sits beside a flash block's command path and strengthens protection for pages that have held their data for a long time. The top pages of the block are reserved as custodian pages. Each custodian page is divided into a fixed number of parity slots. All other pages are data pages that normally carry only the regular ECC. The controller keeps an age for every written data page, advanced by an age tick. When a page reaches the age limit, the controller promotes it in the background. Promotion has two steps: a read of the page that feeds the strong encoder, then a write of the resulting parity into a free custodian slot. The page is then recorded as a client of that slot.

Host reads and writes enter through a valid/ready request port. Every access leaves on a command port as {op, page, slot} tokens with a valid/ready handshake. A host read of a client page becomes two consecutive tokens: one for the client page and one for its custodian page and slot, so the decoder receives both. A host write to a client page releases its slot. Host requests always win over background work. When all slots are taken, a status flag is raised and promotion pauses.

Top module: `cpx_ctrl`

## Requirements
- R1: After reset, cmd_valid is 0, cust_full is 0 and host_req_ready is 1; no page is a client and every slot is free.
- R2: An accepted host write emits one token with op 1 (plain write) for the requested page and slot 0, and resets that page's age to zero.
- R3: An accepted host read of a page that is not a client emits one token with op 0 (plain read) for that page and slot 0.
- R4: A written data page that has seen AGE_LIMIT age ticks since its last host write is promoted. The controller emits op 2 (background read) for the page, then op 3 (parity write) for the custodian page and sub-slot. Global slot s maps to custodian page NUM_DATA + s / SLOTS_PER_PAGE and sub-slot s % SLOTS_PER_PAGE. The lowest-indexed eligible page goes first, and it takes the lowest-numbered free slot.
- R5: Pages that were never written, and custodian pages (index NUM_DATA and above), are never promoted. Host writes to a custodian page are passed through as plain writes and are not tracked.
- R6: A host read of a client page emits op 4 for the client page and its sub-slot. In the very next transfer it emits op 5 for the matching custodian page and the same sub-slot.
- R7: A host write to a client page emits a plain write, clears the client mark so later reads are plain, and frees its slot for reuse.
- R8: A host request that is pending while the controller is idle is served before any background token. A promotion interrupted between its read and its parity write resumes with the parity write after the host tokens.
- R9: A host write to a page between its background read and its parity write cancels the promotion: no parity write is emitted and the reserved slot is freed.
- R10: cust_full is 1 exactly while every slot is reserved or in use. While it is 1, no background read is issued. Freeing a slot lets a waiting page be promoted.
- R11: A token stays on cmd_op, cmd_page and cmd_slot unchanged while cmd_valid is 1 and cmd_ready is 0. host_req_ready is 1 only while no token is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| age_tick | input | 1 | Advances the age of every written, non-client data page |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Request accepted on this cycle's edge |
| host_req_write | input | 1 | 1 for write, 0 for read |
| host_req_page | input | PG_W | Page addressed by the host |
| cmd_valid | output | 1 | Token present on the command port |
| cmd_ready | input | 1 | Downstream takes the token |
| cmd_op | output | 3 | 0 read, 1 write, 2 background read, 3 parity write, 4 client read, 5 custodian read |
| cmd_page | output | PG_W | Page of the token |
| cmd_slot | output | SUB_W | Sub-slot within the custodian page |
| cust_full | output | 1 | All parity slots are reserved or used |

## Verification
Timing from stimulus to result is fixed. A host request accepted on an edge puts its token on the command port from the next edge. The second token of a client read appears one edge after the first is taken. A tick that brings a page to the limit produces the background read one edge after the tick's edge. Its parity write comes one edge after the read is accepted, unless a host request is waiting in that idle cycle. The bench relies on this. It presents a host request exactly in the idle cycle between a background read and its parity write, to exercise priority and cancellation. A scoreboard queue holds the tokens in the order they must appear. Every transfer is sampled mid-cycle, after the falling edge, when the handshake signals are settled.

// File: rtl/cpx_pkg.sv
package cpx_pkg;
    typedef enum logic [2:0] {
        OP_RD    = 3'd0,
        OP_WR    = 3'd1,
        OP_BGRD  = 3'd2,
        OP_PARWR = 3'd3,
        OP_CLIRD = 3'd4,
        OP_CUSRD = 3'd5
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } st_e;
endpackage

// File: rtl/cpx_age_tracker.sv
module cpx_age_tracker #(
    parameter int NUM_DATA  = 14,
    parameter int PG_W      = 4,
    parameter int AGE_LIMIT = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                clr_en,
    input  logic [PG_W-1:0]     clr_pg,
    input  logic                mark_en,
    input  logic [PG_W-1:0]     mark_pg,
    input  logic                excl_en,
    input  logic [PG_W-1:0]     excl_pg,
    output logic [NUM_DATA-1:0] client_o,
    output logic                cand_v,
    output logic [PG_W-1:0]     cand_pg
);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1);

    typedef struct packed {
        logic [NUM_DATA-1:0][AGE_W-1:0] age;
        logic [NUM_DATA-1:0]            written;
        logic [NUM_DATA-1:0]            client;
    } trk_t;

    trk_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        for (int i = 0; i < NUM_DATA; i++) begin
            if (clr_en && clr_pg == PG_W'(i)) begin
                t_d.age[i]     = '0;
                t_d.written[i] = 1'b1;
                t_d.client[i]  = 1'b0;
            end else begin
                if (mark_en && mark_pg == PG_W'(i)) begin
                    t_d.client[i] = 1'b1;
                end
                if (tick && t_q.written[i] && !t_q.client[i] &&
                    t_q.age[i] < AGE_W'(AGE_LIMIT)) begin
                    t_d.age[i] = t_q.age[i] + AGE_W'(1);
                end
            end
        end
    end

    always_comb begin
        cand_v  = 1'b0;
        cand_pg = '0;
        for (int i = NUM_DATA - 1; i >= 0; i--) begin
            if (t_q.written[i] && !t_q.client[i] &&
                t_q.age[i] == AGE_W'(AGE_LIMIT) &&
                !(excl_en && excl_pg == PG_W'(i))) begin
                cand_v  = 1'b1;
                cand_pg = PG_W'(i);
            end
        end
    end

    assign client_o = t_q.client;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    // R4: a page is never marked as client twice without a write in between
    p_single_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |-> !client_o[mark_pg]);
endmodule

// File: rtl/cpx_slot_pool.sv
module cpx_slot_pool #(
    parameter int NUM_SLOTS = 8,
    parameter int SLOT_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic              rel_en,
    input  logic [SLOT_W-1:0] rel_idx,
    output logic [SLOT_W-1:0] lo_free,
    output logic              full
);
    typedef struct packed {
        logic [NUM_SLOTS-1:0] busy;
    } pool_t;

    pool_t p_d, p_q;

    always_comb begin
        lo_free = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!p_q.busy[i]) lo_free = SLOT_W'(i);
        end
    end

    always_comb begin
        p_d = p_q;
        if (alloc_en) p_d.busy[lo_free] = 1'b1;
        if (rel_en)   p_d.busy[rel_idx] = 1'b0;
    end

    assign full = &p_q.busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    p_no_alloc_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);
    p_rel_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rel_en |-> p_q.busy[rel_idx]);
endmodule

// File: rtl/cpx_ctrl.sv
module cpx_ctrl #(
    parameter int NUM_PAGES      = 16,
    parameter int CUST_PAGES     = 2,
    parameter int SLOTS_PER_PAGE = 4,
    parameter int AGE_LIMIT      = 3,
    parameter int PG_W           = $clog2(NUM_PAGES),
    parameter int SUB_W          = (SLOTS_PER_PAGE > 1) ? $clog2(SLOTS_PER_PAGE) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             age_tick,
    input  logic             host_req_valid,
    output logic             host_req_ready,
    input  logic             host_req_write,
    input  logic [PG_W-1:0]  host_req_page,
    output logic             cmd_valid,
    input  logic             cmd_ready,
    output logic [2:0]       cmd_op,
    output logic [PG_W-1:0]  cmd_page,
    output logic [SUB_W-1:0] cmd_slot,
    output logic             cust_full
);
    import cpx_pkg::*;

    localparam int NUM_DATA  = NUM_PAGES - CUST_PAGES;
    localparam int NUM_SLOTS = CUST_PAGES * SLOTS_PER_PAGE;
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

    typedef struct packed {
        st_e                            st;
        logic [2:0]                     op;
        logic [PG_W-1:0]                pg;
        logic [SUB_W-1:0]               sl;
        logic                           sv;
        logic [2:0]                     sop;
        logic [PG_W-1:0]                spg;
        logic [SUB_W-1:0]               ssl;
        logic                           pv;
        logic [PG_W-1:0]                ppg;
        logic [SLOT_W-1:0]              pslot;
        logic                           cm;
        logic [NUM_DATA-1:0][SLOT_W-1:0] map;
    } ctl_t;

    ctl_t c_d, c_q;

    logic                clr_en, mark_en, alloc_en, rel_en;
    logic [SLOT_W-1:0]   rel_idx, lo_free;
    logic [NUM_DATA-1:0] client_vec;
    logic                cand_v, full;
    logic [PG_W-1:0]     cand_pg, didx;
    logic                in_rng;
    logic [SLOT_W-1:0]   hslot;

    function automatic logic [PG_W-1:0] cust_pg(input logic [SLOT_W-1:0] s);
        return PG_W'(NUM_DATA + int'(s) / SLOTS_PER_PAGE);
    endfunction

    function automatic logic [SUB_W-1:0] sub_of(input logic [SLOT_W-1:0] s);
        return SUB_W'(int'(s) % SLOTS_PER_PAGE);
    endfunction

    cpx_age_tracker #(
        .NUM_DATA (NUM_DATA),
        .PG_W     (PG_W),
        .AGE_LIMIT(AGE_LIMIT)
    ) u_trk (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (age_tick),
        .clr_en  (clr_en),
        .clr_pg  (host_req_page),
        .mark_en (mark_en),
        .mark_pg (c_q.ppg),
        .excl_en (c_q.pv),
        .excl_pg (c_q.ppg),
        .client_o(client_vec),
        .cand_v  (cand_v),
        .cand_pg (cand_pg)
    );

    cpx_slot_pool #(
        .NUM_SLOTS(NUM_SLOTS),
        .SLOT_W   (SLOT_W)
    ) u_pool (
        .clk     (clk),
        .rst_n   (rst_n),
        .alloc_en(alloc_en),
        .rel_en  (rel_en),
        .rel_idx (rel_idx),
        .lo_free (lo_free),
        .full    (full)
    );

    assign in_rng = host_req_page < PG_W'(NUM_DATA);
    assign didx   = in_rng ? host_req_page : '0;
    assign hslot  = c_q.map[didx];

    always_comb begin
        c_d      = c_q;
        clr_en   = 1'b0;
        mark_en  = 1'b0;
        alloc_en = 1'b0;
        rel_en   = 1'b0;
        rel_idx  = '0;
        case (c_q.st)
            ST_IDLE: begin
                if (host_req_valid) begin
                    c_d.st = ST_SEND;
                    c_d.pg = host_req_page;
                    c_d.sl = '0;
                    c_d.sv = 1'b0;
                    if (host_req_write) begin
                        c_d.op = OP_WR;
                        if (in_rng) begin
                            clr_en = 1'b1;
                            if (client_vec[didx]) begin
                                rel_en  = 1'b1;
                                rel_idx = hslot;
                            end
                            if (c_q.pv && c_q.ppg == host_req_page) begin
                                rel_en  = 1'b1;
                                rel_idx = c_q.pslot;
                                c_d.pv  = 1'b0;
                            end
                        end
                    end else if (in_rng && client_vec[didx]) begin
                        c_d.op  = OP_CLIRD;
                        c_d.sl  = sub_of(hslot);
                        c_d.sv  = 1'b1;
                        c_d.sop = OP_CUSRD;
                        c_d.spg = cust_pg(hslot);
                        c_d.ssl = sub_of(hslot);
                    end else begin
                        c_d.op = OP_RD;
                    end
                end else if (c_q.pv) begin
                    c_d.st = ST_SEND;
                    c_d.op = OP_PARWR;
                    c_d.pg = cust_pg(c_q.pslot);
                    c_d.sl = sub_of(c_q.pslot);
                    c_d.sv = 1'b0;
                    c_d.cm = 1'b1;
                end else if (cand_v && !full) begin
                    c_d.st    = ST_SEND;
                    c_d.op    = OP_BGRD;
                    c_d.pg    = cand_pg;
                    c_d.sl    = '0;
                    c_d.sv    = 1'b0;
                    alloc_en  = 1'b1;
                    c_d.pv    = 1'b1;
                    c_d.ppg   = cand_pg;
                    c_d.pslot = lo_free;
                end
            end
            ST_SEND: begin
                if (cmd_ready) begin
                    if (c_q.sv) begin
                        c_d.op = c_q.sop;
                        c_d.pg = c_q.spg;
                        c_d.sl = c_q.ssl;
                        c_d.sv = 1'b0;
                    end else begin
                        c_d.st = ST_IDLE;
                    end
                    if (c_q.cm) begin
                        mark_en            = 1'b1;
                        c_d.map[c_q.ppg]   = c_q.pslot;
                        c_d.pv             = 1'b0;
                        c_d.cm             = 1'b0;
                    end
                end
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign host_req_ready = (c_q.st == ST_IDLE);
    assign cmd_valid      = (c_q.st == ST_SEND);
    assign cmd_op         = c_q.op;
    assign cmd_page       = c_q.pg;
    assign cmd_slot       = c_q.sl;
    assign cust_full      = full;

    p_hold_tok_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) &&
                                       $stable(cmd_page) && $stable(cmd_slot)));
    p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        host_req_ready |-> !cmd_valid);
    p_pair_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == OP_CLIRD) |=>
            (cmd_valid && cmd_op == OP_CUSRD));
    p_parwr_cust_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_PARWR) |-> cmd_page >= PG_W'(NUM_DATA));
    p_bgrd_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_BGRD) |-> cmd_page < PG_W'(NUM_DATA));
endmodule

// File: tb/cpx_ctrl_tb.sv
`timescale 1ns/1ps
module cpx_ctrl_tb;
    localparam int PG_W  = 4;
    localparam int SUB_W = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic age_tick = 1'b0;
    logic host_req_valid = 1'b0;
    logic host_req_write = 1'b0;
    logic [PG_W-1:0] host_req_page = '0;
    logic cmd_ready = 1'b1;
    logic host_req_ready, cmd_valid, cust_full;
    logic [2:0] cmd_op;
    logic [PG_W-1:0] cmd_page;
    logic [SUB_W-1:0] cmd_slot;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 0;

    typedef struct packed {
        logic [2:0] op;
        logic [PG_W-1:0] pg;
        logic [SUB_W-1:0] sl;
    } tok_t;
    tok_t expq[$];
    string reqq[$];

    always #2 clk = ~clk;

    cpx_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .age_tick(age_tick),
        .host_req_valid(host_req_valid), .host_req_ready(host_req_ready),
        .host_req_write(host_req_write), .host_req_page(host_req_page),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .cmd_slot(cmd_slot), .cust_full(cust_full)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_tok(input int op, input int pg, input int sl, input string req);
        tok_t t;
        t.op = 3'(op); t.pg = PG_W'(pg); t.sl = SUB_W'(sl);
        expq.push_back(t);
        reqq.push_back(req);
    endtask

    // expected parity-write token for global slot s (R4 mapping)
    task automatic expect_pw(input int s, input string req);
        expect_tok(3, 14 + s / 4, s % 4, req);
    endtask

    // monitor: sample mid-cycle, after inputs settle at the falling edge
    always begin
        @(negedge clk);
        #1;
        if (rst_n && cmd_valid && cmd_ready) begin
            tok_t got;
            got.op = cmd_op; got.pg = cmd_page; got.sl = cmd_slot;
            if (expq.size() == 0) begin
                chk(0, "R5", "unexpected token op/page", int'({cmd_op, cmd_page}), -1);
            end else begin
                tok_t e;
                string r;
                e = expq.pop_front();
                r = reqq.pop_front();
                chk(got == e, r, "token {op,page,slot}", int'(got), int'(e));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d cycles", cycles, 100000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic host_op(input bit wr, input int pg);
        host_req_valid = 1'b1;
        host_req_write = wr;
        host_req_page  = PG_W'(pg);
        while (!host_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        host_req_valid = 1'b0;
    endtask

    task automatic tick_once();
        age_tick = 1'b1;
        @(negedge clk);
        age_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_valid == 0, "R1", "cmd_valid", int'(cmd_valid), 0);
        chk(cust_full == 0, "R1", "cust_full", int'(cust_full), 0);
        chk(host_req_ready == 1, "R1", "host_req_ready", int'(host_req_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);

        // R5: ticks with no written page produce nothing
        repeat (5) tick_once();
        idle(5);

        // R2 write, R5 custodian page pass-through, R3 plain read
        expect_tok(1, 2, 0, "R2"); host_op(1, 2);
        expect_tok(1, 15, 0, "R5"); host_op(1, 15);
        expect_tok(0, 2, 0, "R3"); host_op(0, 2);
        idle(4);

        // R2: rewrite resets age
        tick_once(); tick_once();
        expect_tok(1, 2, 0, "R2"); host_op(1, 2);
        tick_once(); tick_once();
        idle(6);
        // R4: third tick after write promotes page 2 into slot 0
        expect_tok(2, 2, 0, "R4"); expect_pw(0, "R4");
        tick_once();
        idle(10);

        // R6: paired read
        expect_tok(4, 2, 0, "R6"); expect_tok(5, 14, 0, "R6");
        host_op(0, 2);
        idle(4);

        // R8: host read lands between background read and parity write
        expect_tok(1, 5, 0, "R2"); host_op(1, 5);
        tick_once(); tick_once();
        expect_tok(2, 5, 0, "R8");
        expect_tok(4, 2, 0, "R8"); expect_tok(5, 14, 0, "R8");
        expect_pw(1, "R8");
        tick_once();
        idle(2);
        host_op(0, 2);
        idle(10);

        // R11: backpressure holds token and blocks host
        cmd_ready = 1'b0;
        expect_tok(0, 3, 0, "R11");
        host_op(0, 3);
        chk(cmd_valid == 1, "R11", "cmd_valid under stall", int'(cmd_valid), 1);
        idle(3);
        chk(cmd_valid == 1 && cmd_op == 3'd0 && cmd_page == 4'd3, "R11",
            "held token page", int'(cmd_page), 3);
        chk(host_req_ready == 0, "R11", "host_req_ready under stall", int'(host_req_ready), 0);
        cmd_ready = 1'b1;
        idle(4);

        // R7: write to client clears mark and frees slot 0
        expect_tok(1, 2, 0, "R7"); host_op(1, 2);
        expect_tok(0, 2, 0, "R7"); host_op(0, 2);
        expect_tok(2, 2, 0, "R7"); expect_pw(0, "R7");
        repeat (3) tick_once();
        idle(10);

        // R9: write between background read and parity write cancels
        expect_tok(1, 7, 0, "R9"); host_op(1, 7);
        tick_once(); tick_once();
        expect_tok(2, 7, 0, "R9"); expect_tok(1, 7, 0, "R9");
        tick_once();
        idle(2);
        host_op(1, 7);
        idle(10);
        expect_tok(2, 7, 0, "R9"); expect_pw(2, "R9");
        repeat (3) tick_once();
        idle(10);

        // R10: fill remaining slots in page order
        for (int p = 8; p <= 12; p++) begin
            expect_tok(1, p, 0, "R10");
            host_op(1, p);
        end
        for (int p = 8; p <= 12; p++) begin
            expect_tok(2, p, 0, "R4");
            expect_pw(p - 5, "R4");
        end
        repeat (3) tick_once();
        idle(30);
        chk(cust_full == 1, "R10", "cust_full when all used", int'(cust_full), 1);
        expect_tok(1, 13, 0, "R10"); host_op(1, 13);
        repeat (3) tick_once();
        idle(10);
        chk(cust_full == 1, "R10", "cust_full still set", int'(cust_full), 1);
        expect_tok(1, 9, 0, "R10"); expect_tok(2, 13, 0, "R10"); expect_pw(4, "R10");
        host_op(1, 9);
        idle(10);
        chk(cust_full == 1, "R10", "cust_full after refill", int'(cust_full), 1);
        expect_tok(4, 13, 0, "R6"); expect_tok(5, 15, 0, "R6");
        host_op(0, 13);
        expect_tok(0, 9, 0, "R7");
        host_op(0, 9);
        idle(10);

        chk(expq.size() == 0, "R8", "tokens still expected", expq.size(), 0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule